// File: doc/BRIEF.md
# Protected Page Write Commit Controller

This block sits behind a serial slave front end and in front of a 256 x 8 storage array. The front end hands it a word address, then a stream of data bytes, then a stop. The bytes collect in a 16-entry page buffer. The high half of the pointer selects the page and stays fixed. The low half advances once per byte and wraps inside the page, so a long burst overwrites the earliest entries. The stop opens a self-timed write window, and `busy` stays high for the whole window. During the first sixteen clocks of that window, every buffer entry that received a byte is offered to the array in ascending entry order, one entry per clock.

Two protection sources filter each byte at commit time. The first is a hardware protect input that blocks the whole array. The second is a software lock that blocks the lower half of the address space. The lock is set by a lock request followed by a stop, and nothing but reset clears it. A protected byte is dropped silently, and the window still runs its full length. While the window runs, the block ignores every incoming strobe.

Top module: `page_commit_ctl`

## Requirements
- R1: After reset, `busy` and `memWe` are low, and the software lock is clear, so a later unprotected write to an address below 80h reaches the array.
- R2: `addrLoad` loads the whole pointer. Each accepted data byte is stored at the pointer's low four bits, and only those bits then increment. The committed address is {page bits from `addrIn[7:4]`, entry index}, so a burst starting at 3Eh lands at 3Eh, 3Fh and then 30h.
- R3: When more than 16 bytes arrive before a stop, the later bytes replace the earlier ones in arrival order, so entry k holds the last byte that was stored there.
- R4: A stop that follows an accepted address load or lock request raises `busy` on the next clock. `busy` then stays high for exactly `WR_CYCLES` clocks. A stop with no such sequence pending starts nothing.
- R5: Commit drives `memWe` only while `busy` is high. It writes only the entries that received a byte since the last address load, one per clock, in ascending entry index.
- R6: The write window runs its full `WR_CYCLES` length even when protection blocks every byte.
- R7: A lock request followed by a stop, with `hwProtect` low, sets the software lock. From then on, no address whose top bit is 0 is written, while addresses 80h-FFh still are.
- R8: The software lock cannot be cleared. A further lock request is ignored: the stop after it starts no window, and the lower half stays blocked.
- R9: While `hwProtect` is high during commit, no location is written.
- R10: While `hwProtect` is high, a lock request is ignored: the following stop starts no window, and the lock stays clear.
- R11: Address loads, data bytes and lock requests that arrive while `busy` is high are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrLoad | input | 1 | Word address strobe; starts a write sequence |
| addrIn | input | 8 | Word address |
| dataStrobe | input | 1 | Data byte strobe |
| dataIn | input | 8 | Data byte |
| stopStrobe | input | 1 | Stop seen on the bus |
| lockReq | input | 1 | Software lock command strobe |
| hwProtect | input | 1 | Hardware protect, high blocks the whole array |
| memWe | output | 1 | Array write enable |
| memAddr | output | 8 | Array write address |
| memData | output | 8 | Array write data |
| busy | output | 1 | High for the self-timed write window |

## Verification
The bench builds the block with its default 8-bit address and 4-bit page index, and with `WR_CYCLES` set to 40. A window of that length can be counted clock by clock on every commit, and it is still longer than the sixteen commit slots, so the idle tail of the window is exercised too. The short window also makes room for strobes injected in the middle of a busy window, a burst of eighteen bytes, and the full sequence that sets the lock and then probes it, all within one short run.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic ldAddr;      // take a new pointer, start a write sequence
    logic capByte;     // store dataIn at the pointer
    logic clrValid;    // forget all buffered entries
    logic startCommit; // window opens next clock
    logic commitEn;    // this clock is a commit slot
  } dpCtrl_t;
endpackage

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import page_commit_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 2500000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    addrLoad,
  input  logic    dataStrobe,
  input  logic    stopStrobe,
  input  logic    lockReq,
  input  logic    hwProtect,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    lockQ
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] COMMIT_END = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0] cnt;
  logic armed, lockPend;
  logic accStop, accAddr, accLock, accData, lastCyc;

  always_comb begin
    accStop = !busy && stopStrobe && armed;
    accAddr = !busy && !stopStrobe && addrLoad;
    accLock = !busy && !stopStrobe && !addrLoad && lockReq && !lockQ && !hwProtect;
    accData = !busy && !stopStrobe && !addrLoad && !lockReq && dataStrobe
              && armed && !lockPend;
    lastCyc = busy && (cnt == LAST_CNT);
    ctl.ldAddr      = accAddr;
    ctl.capByte     = accData;
    ctl.clrValid    = accAddr || accLock || lastCyc;
    ctl.startCommit = accStop;
    ctl.commitEn    = busy && (cnt < COMMIT_END);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      armed    <= 1'b0;
      lockPend <= 1'b0;
      lockQ    <= 1'b0;
    end else if (busy) begin
      if (lastCyc) begin
        busy     <= 1'b0;
        armed    <= 1'b0;
        lockPend <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (accStop) begin
      busy <= 1'b1;
      cnt  <= '0;
      if (lockPend && !hwProtect) lockQ <= 1'b1;
    end else if (accAddr) begin
      armed    <= 1'b1;
      lockPend <= 1'b0;
    end else if (accLock) begin
      armed    <= 1'b1;
      lockPend <= 1'b1;
    end
  end
endmodule

// File: rtl/page_commit_dp.sv
module page_commit_dp
  import page_commit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              lockQ,
  input  logic              hwProtect,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - PAGE_W;

  logic [HI_W-1:0]       ptrHi;
  logic [PAGE_W-1:0]     ptrLo;
  logic [PAGE_W-1:0]     idx;
  logic [PAGE_BYTES-1:0] valid;
  logic [DATA_W-1:0]     entry [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrHi <= '0;
      ptrLo <= '0;
      idx   <= '0;
    end else begin
      if (ctl.ldAddr) begin
        ptrHi <= addrIn[ADDR_W-1:PAGE_W];
        ptrLo <= addrIn[PAGE_W-1:0];
      end else if (ctl.capByte) begin
        ptrLo <= ptrLo + 1'b1;
      end
      if (ctl.startCommit)   idx <= '0;
      else if (ctl.commitEn) idx <= idx + 1'b1;
    end
  end

  for (genvar e = 0; e < PAGE_BYTES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)                                              valid[e] <= 1'b0;
      else if (ctl.clrValid)                                  valid[e] <= 1'b0;
      else if (ctl.capByte && ptrLo == PAGE_W'(e))            valid[e] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (ctl.capByte && ptrLo == PAGE_W'(e)) entry[e] <= dataIn;
    end
  end

  logic lowHalf;
  always_comb begin
    memAddr = {ptrHi, idx};
    memData = entry[idx];
    lowHalf = !memAddr[ADDR_W-1];
    memWe   = ctl.commitEn && valid[idx] && !hwProtect && !(lockQ && lowHalf);
  end
endmodule

// File: rtl/page_commit_ctl.sv
module page_commit_ctl
  import page_commit_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataStrobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              stopStrobe,
  input  logic              lockReq,
  input  logic              hwProtect,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              busy
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  dpCtrl_t ctl;
  logic    lockQ;

  page_commit_ctrl #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .dataStrobe(dataStrobe),
    .stopStrobe(stopStrobe), .lockReq(lockReq), .hwProtect(hwProtect),
    .ctl(ctl), .busy(busy), .lockQ(lockQ)
  );

  page_commit_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrIn(addrIn), .dataIn(dataIn),
    .lockQ(lockQ), .hwProtect(hwProtect), .memWe(memWe),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/page_commit_chk.sv
module page_commit_chk #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 2500000
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopStrobe,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);
  localparam int BC_W = $clog2(WR_CYCLES + 1) + 1;
  logic [BC_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // R5
  we_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopStrobe));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == BC_W'(WR_CYCLES));

  // R2
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe) && $past(busy)) |->
      memAddr[ADDR_W-1:PAGE_W] == $past(memAddr[ADDR_W-1:PAGE_W]));

  // R5
  commit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe) && $past(busy)) |->
      memAddr[PAGE_W-1:0] == PAGE_W'($past(memAddr[PAGE_W-1:0]) + 1'b1));
endmodule

bind page_commit_ctl page_commit_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) chk_i (
  .clk(clk), .rstN(rstN), .stopStrobe(stopStrobe), .busy(busy),
  .memWe(memWe), .memAddr(memAddr)
);

// File: tb/page_commit_ctl_tb_top.sv
module page_commit_ctl_tb_top;
  localparam int WRC = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrLoad = 1'b0, dataStrobe = 1'b0, stopStrobe = 1'b0;
  logic lockReq = 1'b0, hwProtect = 1'b0;
  logic [7:0] addrIn = '0, dataIn = '0;
  logic memWe, busy;
  logic [7:0] memAddr, memData;

  page_commit_ctl #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
    .dataStrobe(dataStrobe), .dataIn(dataIn), .stopStrobe(stopStrobe),
    .lockReq(lockReq), .hwProtect(hwProtect), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .busy(busy)
  );

  always #2 clk = ~clk;

  logic [7:0] shadow [256];
  logic [7:0] wrLog  [256];
  int wrTotal = 0;
  int nChecks = 0;
  int nFail = 0;

  always @(posedge clk) begin
    if (memWe) begin
      shadow[memAddr] <= memData;
      wrLog[wrTotal[7:0]] <= memAddr;
      wrTotal <= wrTotal + 1;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic loadAddr(logic [7:0] a);
    @(negedge clk); addrLoad = 1'b1; addrIn = a;
    @(negedge clk); addrLoad = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] d);
    @(negedge clk); dataStrobe = 1'b1; dataIn = d;
    @(negedge clk); dataStrobe = 1'b0;
  endtask

  task automatic lockCmd();
    @(negedge clk); lockReq = 1'b1;
    @(negedge clk); lockReq = 1'b0;
  endtask

  // stop, then count busy clocks until idle
  task automatic stopCount(output int len);
    @(negedge clk); stopStrobe = 1'b1;
    @(negedge clk); stopStrobe = 1'b0;
    len = 0;
    while (busy) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    check("R1", busy, 0, "busy after reset");
    check("R1", memWe, 0, "memWe after reset");
  endtask

  task automatic tPageWrap();
    int len, base;
    base = wrTotal;
    loadAddr(8'h3E);
    sendByte(8'hA1); sendByte(8'hB2); sendByte(8'hC3);
    stopCount(len);
    check("R4", len, WRC, "window length");
    check("R5", wrTotal - base, 3, "write count");
    check("R5", wrLog[base[7:0]], 8'h30, "first committed entry");
    check("R2", shadow[8'h3E], 8'hA1, "byte at 3E");
    check("R2", shadow[8'h3F], 8'hB2, "byte at 3F");
    check("R2", shadow[8'h30], 8'hC3, "wrapped byte at 30");
    check("R2", shadow[8'h40], 8'hEE, "no spill into next page");
  endtask

  task automatic tLoneStop();
    int len;
    stopCount(len);
    check("R4", len, 0, "stop with nothing pending");
  endtask

  task automatic tOverrun();
    int len, base;
    base = wrTotal;
    loadAddr(8'h50);
    for (int i = 0; i < 18; i++) sendByte(8'h60 + 8'(i));
    stopCount(len);
    check("R3", wrTotal - base, 16, "write count after overrun");
    check("R3", shadow[8'h50], 8'h70, "entry 0 overwritten");
    check("R3", shadow[8'h51], 8'h71, "entry 1 overwritten");
    check("R3", shadow[8'h52], 8'h62, "entry 2 kept");
    check("R3", shadow[8'h5F], 8'h6F, "entry 15 kept");
  endtask

  task automatic tBusyDiscard();
    int len;
    loadAddr(8'h90); sendByte(8'h11);
    @(negedge clk); stopStrobe = 1'b1;
    @(negedge clk); stopStrobe = 1'b0; addrLoad = 1'b1; addrIn = 8'h20;
    @(negedge clk); addrLoad = 1'b0; dataStrobe = 1'b1; dataIn = 8'h99;
    @(negedge clk); dataStrobe = 1'b0; lockReq = 1'b1;
    @(negedge clk); lockReq = 1'b0;
    while (busy) @(negedge clk);
    check("R11", shadow[8'h90], 8'h11, "write before discard");
    stopCount(len);
    check("R11", len, 0, "address load during busy dropped");
    check("R11", shadow[8'h20], 8'hEE, "byte during busy dropped");
  endtask

  task automatic tHardware();
    int len, base;
    hwProtect = 1'b1;
    base = wrTotal;
    loadAddr(8'h05); sendByte(8'h55);
    stopCount(len);
    check("R6", len, WRC, "full window under protect");
    check("R9", wrTotal - base, 0, "writes under protect");
    lockCmd();
    stopCount(len);
    check("R10", len, 0, "lock request under protect");
    hwProtect = 1'b0;
    loadAddr(8'h06); sendByte(8'h66);
    stopCount(len);
    check("R10", shadow[8'h06], 8'h66, "lower half still writable");
    check("R1", shadow[8'h05], 8'hEE, "blocked byte absent");
  endtask

  task automatic tLock();
    int len, base;
    base = wrTotal;
    lockCmd();
    stopCount(len);
    check("R7", len, WRC, "lock window length");
    loadAddr(8'h07); sendByte(8'h77);
    stopCount(len);
    check("R6", len, WRC, "full window when lock blocks");
    check("R7", shadow[8'h07], 8'hEE, "lower half blocked");
    loadAddr(8'h87); sendByte(8'h88);
    stopCount(len);
    check("R7", shadow[8'h87], 8'h88, "upper half written");
    check("R7", wrTotal - base, 1, "only upper byte written");
    lockCmd();
    stopCount(len);
    check("R8", len, 0, "second lock request ignored");
    loadAddr(8'h08); sendByte(8'h08);
    stopCount(len);
    check("R8", shadow[8'h08], 8'hEE, "lock still holds");
  endtask

  initial begin
    #(4 * 150000);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 8'hEE;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPageWrap();
    tLoneStop();
    tOverrun();
    tBusyDiscard();
    tHardware();
    tLock();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule